// File: doc/BRIEF.md
# Dual Warp Instruction Issue Scheduler

This block is the issue stage shared by two cooperating schedulers inside one streaming multiprocessor. The resident warps are split between the schedulers by the parity of their warp ID. Scheduler A owns the odd IDs and scheduler B owns the even IDs. Each cycle, a scheduler that is not busy searches its own warps in round-robin order for one whose ready bit is set. It then starts that warp's instruction on its half of the execution lanes.

A scheduler drives only half of the lanes, so every warp instruction goes out as two half-warp issues on back-to-back cycles. Half-warp 0 comes first and half-warp 1 follows. During the second cycle the scheduler repeats the held warp and does not arbitrate. Double-precision work is exclusive: while either scheduler has a double-precision instruction on the lanes, in either half, the other scheduler issues nothing. When two starts collide and at least one of them is double precision, a toggling priority bit decides which one goes. The ready mask and the instruction class of each warp come from upstream logic. The issue outputs are combinational in the cycle of selection.

Top module: `dual_warp_issue`

## Requirements
- R1: Scheduler A only ever issues odd warp IDs, and scheduler B only ever issues even warp IDs.
- R2: A half-warp 0 issue names a warp whose ready bit is set in that same cycle. A scheduler with no ready warp of its own parity and no instruction in progress issues nothing.
- R3: Each started instruction issues on exactly two consecutive cycles, with the half-warp output at 0 and then at 1. The warp ID and the class are the same in both cycles, and the scheduler does not arbitrate in the second cycle.
- R4: The second half-warp issue takes place even when the warp's ready bit has dropped after the first half.
- R5: A scheduler's search begins at the warp that follows, in its own ID order, the warp it last started. The search wraps from its highest warp back to its lowest.
- R6: In every cycle in which one scheduler issues either half of a double-precision instruction, the other scheduler issues nothing.
- R7: A scheduler does not start a double-precision instruction while the other scheduler is issuing its second half-warp. It retries in a later cycle.
- R8: Suppose both schedulers would start in the same cycle and at least one candidate is double precision. Then a priority bit lets exactly one of them start: A when the bit is clear, B when it is set. The bit toggles after each such conflict. The losing scheduler issues nothing in that cycle or the next, and it keeps its round-robin position.
- R9: The class input of each warp is a 2-bit field at bits [2w+1:2w], coded 0 integer, 1 single-precision float and 2 double precision. Code 3 is treated as a non-double arithmetic class. The class output repeats the issued warp's code.
- R10: The reset is synchronous and active high. While it is asserted neither scheduler issues. It clears both busy states, returns both searches to their lowest warp, and gives priority to scheduler A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| warpReady | input | NUM_WARPS | Ready bit per warp, indexed by warp ID |
| warpClass | input | 2*NUM_WARPS | Per-warp instruction class, 2 bits per warp |
| issueValidA | output | 1 | Scheduler A issues this cycle |
| issueWarpA | output | $clog2(NUM_WARPS) | Warp ID issued by scheduler A (odd) |
| issueClassA | output | 2 | Class of the instruction issued by A |
| issueHalfA | output | 1 | Half-warp index issued by A |
| issueValidB | output | 1 | Scheduler B issues this cycle |
| issueWarpB | output | $clog2(NUM_WARPS) | Warp ID issued by scheduler B (even) |
| issueClassB | output | 2 | Class of the instruction issued by B |
| issueHalfB | output | 1 | Half-warp index issued by B |

## Verification
A busy flag left set by mistake shows in the very next cycle as a half-warp 1 issue with no half-warp 0 before it. A missing busy flag shows as a second start where the repeat of the first warp was due. A round-robin pointer that is off by one first shows when the next arbitration picks a different warp from the expected one, two cycles after the last start. A wrong priority bit only shows at the next double-precision collision, so the stimulus makes such collisions happen several times in a row, and once again right after a reset.

// File: rtl/dws_pkg.sv
package dws_pkg;

  typedef enum logic [1:0] {
    CLS_INT = 2'd0,
    CLS_SP  = 2'd1,
    CLS_DP  = 2'd2,
    CLS_RSV = 2'd3
  } instClass_e;

  // Control -> datapath strobes; index 0 is scheduler A (odd), 1 is B (even).
  typedef struct packed {
    logic [1:0] start;
    logic [1:0] issue;
    logic [1:0] second;
  } issueStrobe_t;

  // Datapath -> control candidate summary.
  typedef struct packed {
    logic [1:0] found;
    logic [1:0] isDp;
  } candStatus_t;

endpackage

// File: rtl/dws_rr_pick.sv
module dws_rr_pick #(
  parameter int N     = 24,
  parameter int IDX_W = 5
) (
  input  logic [N-1:0]     req,
  input  logic [IDX_W-1:0] last,
  output logic             found,
  output logic [IDX_W-1:0] idx
);

  // Search starts one past the last granted slot and wraps around.
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int k = 1; k <= N; k++) begin
      int cand;
      cand = int'(last) + k;
      if (cand >= N) cand = cand - N;
      if (!found && req[cand]) begin
        found = 1'b1;
        idx   = IDX_W'(cand);
      end
    end
  end

endmodule

// File: rtl/dws_ctrl.sv
module dws_ctrl
  import dws_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  candStatus_t  status,
  output issueStrobe_t strobe
);

  logic [1:0] busy;
  logic [1:0] busyDp;
  logic [1:0] blocked;
  logic [1:0] wantStart;
  logic [1:0] start;
  logic [1:0] second;
  logic       prioB;
  logic       conflict;

  always_comb begin
    // A scheduler in the second half of a double blocks its peer.
    blocked[0] = busy[1] & busyDp[1];
    blocked[1] = busy[0] & busyDp[0];

    // A double may only start when the peer is not mid-instruction.
    wantStart[0] = !rst && !busy[0] && status.found[0] && !blocked[0]
                   && !(status.isDp[0] && busy[1]);
    wantStart[1] = !rst && !busy[1] && status.found[1] && !blocked[1]
                   && !(status.isDp[1] && busy[0]);

    conflict = wantStart[0] && wantStart[1] && (status.isDp[0] || status.isDp[1]);

    start[0] = wantStart[0] && !(conflict && prioB);
    start[1] = wantStart[1] && !(conflict && !prioB);

    second = busy & {2{!rst}};

    strobe.start  = start;
    strobe.second = second;
    strobe.issue  = start | second;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= '0;
      busyDp <= '0;
      prioB  <= 1'b0;
    end else begin
      busy   <= start;
      busyDp <= start & status.isDp;
      if (conflict) prioB <= ~prioB;
    end
  end

  // Exactly one of two colliding starts goes ahead.
  p_one_winner_r8 : assert property (@(posedge clk) disable iff (rst)
    conflict |-> ($countones(start) == 1));

  // The losing scheduler stays silent in the following cycle too.
  p_loser_a_waits_r8 : assert property (@(posedge clk) disable iff (rst)
    (conflict && start[1]) |=> !strobe.issue[0]);
  p_loser_b_waits_r8 : assert property (@(posedge clk) disable iff (rst)
    (conflict && start[0]) |=> !strobe.issue[1]);

  // No double starts next to the peer's second half.
  p_dp_wait_a_r7 : assert property (@(posedge clk) disable iff (rst)
    strobe.second[1] |-> !(strobe.start[0] && status.isDp[0]));
  p_dp_wait_b_r7 : assert property (@(posedge clk) disable iff (rst)
    strobe.second[0] |-> !(strobe.start[1] && status.isDp[1]));

  // Busy never survives without the half-warp 0 that caused it.
  p_second_follows_r3 : assert property (@(posedge clk) disable iff (rst)
    strobe.second[0] |-> $past(strobe.start[0]));

endmodule

// File: rtl/dws_datapath.sv
module dws_datapath
  import dws_pkg::*;
#(
  parameter int NUM_WARPS = 48
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [NUM_WARPS-1:0]         warpReady,
  input  logic [2*NUM_WARPS-1:0]       warpClass,
  input  issueStrobe_t                 strobe,
  output candStatus_t                  status,
  output logic                         issueValidA,
  output logic [$clog2(NUM_WARPS)-1:0] issueWarpA,
  output logic [1:0]                   issueClassA,
  output logic                         issueHalfA,
  output logic                         issueValidB,
  output logic [$clog2(NUM_WARPS)-1:0] issueWarpB,
  output logic [1:0]                   issueClassB,
  output logic                         issueHalfB
);

  localparam int HALF    = NUM_WARPS / 2;
  localparam int LOCAL_W = (HALF > 1) ? $clog2(HALF) : 1;
  localparam int WARP_W  = $clog2(NUM_WARPS);

  logic [1:0][HALF-1:0]      localReady;
  logic [1:0][HALF-1:0][1:0] localCls;
  logic [1:0][LOCAL_W-1:0]   ptr;
  logic [1:0][LOCAL_W-1:0]   pickIdx;
  logic [1:0]                pickFound;
  logic [1:0]                pickDp;
  logic [1:0][WARP_W-1:0]    pickWarp;
  logic [1:0][WARP_W-1:0]    heldWarp;
  logic [1:0][WARP_W-1:0]    outWarp;
  logic [1:0][1:0]           pickCls;
  logic [1:0][1:0]           heldCls;
  logic [1:0][1:0]           outCls;

  for (genvar s = 0; s < 2; s++) begin : g_sched
    // Scheduler 0 owns odd IDs, scheduler 1 owns even IDs.
    localparam int PAR = (s == 0) ? 1 : 0;

    for (genvar j = 0; j < HALF; j++) begin : g_lane
      assign localReady[s][j] = warpReady[2*j + PAR];
      assign localCls[s][j]   = warpClass[2*(2*j + PAR) +: 2];
    end

    dws_rr_pick #(
      .N     (HALF),
      .IDX_W (LOCAL_W)
    ) u_pick (
      .req   (localReady[s]),
      .last  (ptr[s]),
      .found (pickFound[s]),
      .idx   (pickIdx[s])
    );

    assign pickWarp[s] = WARP_W'({pickIdx[s], 1'(PAR)});
    assign pickCls[s]  = localCls[s][pickIdx[s]];
    assign pickDp[s]   = (pickCls[s] == CLS_DP);

    always_ff @(posedge clk) begin
      if (rst) begin
        ptr[s]      <= LOCAL_W'(HALF - 1);
        heldWarp[s] <= '0;
        heldCls[s]  <= '0;
      end else if (strobe.start[s]) begin
        ptr[s]      <= pickIdx[s];
        heldWarp[s] <= pickWarp[s];
        heldCls[s]  <= pickCls[s];
      end
    end

    always_comb begin
      if (strobe.second[s]) begin
        outWarp[s] = heldWarp[s];
        outCls[s]  = heldCls[s];
      end else if (strobe.start[s]) begin
        outWarp[s] = pickWarp[s];
        outCls[s]  = pickCls[s];
      end else begin
        outWarp[s] = '0;
        outCls[s]  = '0;
      end
    end
  end

  assign status.found = pickFound;
  assign status.isDp  = pickDp;

  assign issueValidA = strobe.issue[0];
  assign issueWarpA  = outWarp[0];
  assign issueClassA = outCls[0];
  assign issueHalfA  = strobe.second[0];
  assign issueValidB = strobe.issue[1];
  assign issueWarpB  = outWarp[1];
  assign issueClassB = outCls[1];
  assign issueHalfB  = strobe.second[1];

  // Parity ownership of the warp IDs.
  p_parity_a_r1 : assert property (@(posedge clk) disable iff (rst)
    issueValidA |-> issueWarpA[0]);
  p_parity_b_r1 : assert property (@(posedge clk) disable iff (rst)
    issueValidB |-> !issueWarpB[0]);

  // A first half goes only to a warp that is ready right now.
  p_ready_a_r2 : assert property (@(posedge clk) disable iff (rst)
    (issueValidA && !issueHalfA) |-> warpReady[issueWarpA]);
  p_ready_b_r2 : assert property (@(posedge clk) disable iff (rst)
    (issueValidB && !issueHalfB) |-> warpReady[issueWarpB]);

  // Half 0 is followed by half 1 of the same warp and class.
  p_pair_a_r3 : assert property (@(posedge clk) disable iff (rst)
    (issueValidA && !issueHalfA) |=> (issueValidA && issueHalfA
      && issueWarpA == $past(issueWarpA) && issueClassA == $past(issueClassA)));
  p_pair_b_r3 : assert property (@(posedge clk) disable iff (rst)
    (issueValidB && !issueHalfB) |=> (issueValidB && issueHalfB
      && issueWarpB == $past(issueWarpB) && issueClassB == $past(issueClassB)));

  // Double precision on the lanes excludes the peer.
  p_dp_excl_a_r6 : assert property (@(posedge clk) disable iff (rst)
    (issueValidA && issueClassA == CLS_DP) |-> !issueValidB);
  p_dp_excl_b_r6 : assert property (@(posedge clk) disable iff (rst)
    (issueValidB && issueClassB == CLS_DP) |-> !issueValidA);

endmodule

// File: rtl/dual_warp_issue.sv
module dual_warp_issue
  import dws_pkg::*;
#(
  parameter int NUM_WARPS = 48
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [NUM_WARPS-1:0]         warpReady,
  input  logic [2*NUM_WARPS-1:0]       warpClass,
  output logic                         issueValidA,
  output logic [$clog2(NUM_WARPS)-1:0] issueWarpA,
  output logic [1:0]                   issueClassA,
  output logic                         issueHalfA,
  output logic                         issueValidB,
  output logic [$clog2(NUM_WARPS)-1:0] issueWarpB,
  output logic [1:0]                   issueClassB,
  output logic                         issueHalfB
);

  issueStrobe_t strobe;
  candStatus_t  status;

  dws_ctrl u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .status (status),
    .strobe (strobe)
  );

  dws_datapath #(
    .NUM_WARPS (NUM_WARPS)
  ) u_dp (
    .clk         (clk),
    .rst         (rst),
    .warpReady   (warpReady),
    .warpClass   (warpClass),
    .strobe      (strobe),
    .status      (status),
    .issueValidA (issueValidA),
    .issueWarpA  (issueWarpA),
    .issueClassA (issueClassA),
    .issueHalfA  (issueHalfA),
    .issueValidB (issueValidB),
    .issueWarpB  (issueWarpB),
    .issueClassB (issueClassB),
    .issueHalfB  (issueHalfB)
  );

endmodule

// File: tb/test_dual_warp_issue.sv
`timescale 1ns/1ps
module test_dual_warp_issue;

  localparam int NW = 48;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NW-1:0] warpReady = '0;
  logic [2*NW-1:0] warpClass = '0;
  logic          issueValidA, issueHalfA, issueValidB, issueHalfB;
  logic [5:0]    issueWarpA, issueWarpB;
  logic [1:0]    issueClassA, issueClassB;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  dual_warp_issue #(.NUM_WARPS(NW)) i_dual_warp_issue (
    .clk (clk), .rst (rst), .warpReady (warpReady), .warpClass (warpClass),
    .issueValidA (issueValidA), .issueWarpA (issueWarpA),
    .issueClassA (issueClassA), .issueHalfA (issueHalfA),
    .issueValidB (issueValidB), .issueWarpB (issueWarpB),
    .issueClassB (issueClassB), .issueHalfB (issueHalfB)
  );

  // Expected issue word: {valid, warp[5:0], class[1:0], half}; zero = idle.
  function automatic logic [9:0] ex(int w, int c, int h);
    return {1'b1, 6'(w), 2'(c), 1'(h)};
  endfunction
  localparam logic [9:0] IDLE = 10'd0;

  typedef struct packed {
    logic [47:0] rdy;
    logic [47:0] dp;
    logic [47:0] sp;
    logic [9:0]  expA;
    logic [9:0]  expB;
  } vec_t;

  // Rows exercise R1 R2 R3 R4 R5 R6 R7 R8 R9 in sequence from reset.
  localparam vec_t VEC [0:16] = '{
    '{48'h1E,  48'h0,  48'h4, ex(1,0,0), ex(2,1,0)},  // R1 R2 R9 SP class on B
    '{48'h1E,  48'h0,  48'h4, ex(1,0,1), ex(2,1,1)},  // R3
    '{48'h1E,  48'h0,  48'h4, ex(3,0,0), ex(4,0,0)},  // R5 next after last
    '{48'h0,   48'h0,  48'h0, ex(3,0,1), ex(4,0,1)},  // R4 ready dropped
    '{48'h0,   48'h0,  48'h0, IDLE,      IDLE},       // R2 nothing ready
    '{48'h6,   48'h0,  48'h0, ex(1,0,0), ex(2,0,0)},  // R5 wrap
    '{48'h6,   48'h0,  48'h0, ex(1,0,1), ex(2,0,1)},  // R3
    '{48'h60,  48'h60, 48'h0, ex(5,2,0), IDLE},       // R8 A wins first
    '{48'h60,  48'h60, 48'h0, ex(5,2,1), IDLE},       // R6 second half
    '{48'h60,  48'h60, 48'h0, IDLE,      ex(6,2,0)},  // R8 B wins next
    '{48'h60,  48'h60, 48'h0, IDLE,      ex(6,2,1)},  // R6
    '{48'h120, 48'h20, 48'h0, ex(5,2,0), IDLE},       // R8 mixed conflict
    '{48'h120, 48'h20, 48'h0, ex(5,2,1), IDLE},       // R6
    '{48'h100, 48'h0,  48'h0, IDLE,      ex(8,0,0)},  // R1
    '{48'h180, 48'h80, 48'h0, IDLE,      ex(8,0,1)},  // R7 DP held
    '{48'h80,  48'h80, 48'h0, ex(7,2,0), IDLE},       // R7 retried
    '{48'h80,  48'h80, 48'h0, ex(7,2,1), IDLE}        // R6
  };

  function automatic logic [9:0] gotA();
    return issueValidA ? {1'b1, issueWarpA, issueClassA, issueHalfA} : 10'd0;
  endfunction
  function automatic logic [9:0] gotB();
    return issueValidB ? {1'b1, issueWarpB, issueClassB, issueHalfB} : 10'd0;
  endfunction

  task automatic drive(input logic [47:0] rdy, input logic [47:0] dp,
                       input logic [47:0] sp, input logic [47:0] rsv);
    warpReady = rdy;
    for (int w = 0; w < NW; w++)
      warpClass[2*w +: 2] = dp[w] ? 2'd2 : rsv[w] ? 2'd3 : sp[w] ? 2'd1 : 2'd0;
  endtask

  task automatic checkBoth(input string tag, input logic [9:0] ea, input logic [9:0] eb);
    #1;
    checks++;
    if (gotA() !== ea) begin
      errors++;
      $display("FAIL %s sched A got %h expected %h", tag, gotA(), ea);
    end
    checks++;
    if (gotB() !== eb) begin
      errors++;
      $display("FAIL %s sched B got %h expected %h", tag, gotB(), eb);
    end
  endtask

  task automatic cycle(input string tag, input logic [47:0] rdy, input logic [47:0] dp,
                       input logic [47:0] rsv, input logic [9:0] ea, input logic [9:0] eb);
    @(negedge clk);
    drive(rdy, dp, 48'h0, rsv);
    checkBoth(tag, ea, eb);
  endtask

  task automatic resetCycle(input string tag);
    @(negedge clk);
    rst = 1'b1;
    drive({NW{1'b1}}, 48'h0, 48'h0, 48'h0);
    checkBoth(tag, IDLE, IDLE);
    @(negedge clk);
    rst = 1'b0;
  endtask

  localparam logic [47:0] W47 = 48'h8000_0000_0000;
  localparam logic [47:0] W46 = 48'h4000_0000_0000;

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    drive(VEC[0].rdy, VEC[0].dp, VEC[0].sp, 48'h0);
    checkBoth("table row 0", VEC[0].expA, VEC[0].expB);
    for (int i = 1; i < 17; i++) begin
      @(negedge clk);
      drive(VEC[i].rdy, VEC[i].dp, VEC[i].sp, 48'h0);
      checkBoth($sformatf("table row %0d", i), VEC[i].expA, VEC[i].expB);
    end

    // R10: reset suppresses issue and restores priority to A (R8).
    resetCycle("R10 in reset");
    drive(48'h3, 48'h3, 48'h0, 48'h0);
    checkBoth("R10 priority back to A", ex(1,2,0), IDLE);
    cycle("R10 priority second half", 48'h3, 48'h3, 48'h0, ex(1,2,1), IDLE);

    // R10: reset in mid-instruction clears busy state.
    resetCycle("R10 reset start");
    drive({NW{1'b1}}, 48'h0, 48'h0, 48'h0);
    checkBoth("R10 search from lowest", ex(1,0,0), ex(0,0,0));
    resetCycle("R10 reset mid instr");
    drive(48'h0, 48'h0, 48'h0, 48'h0);
    checkBoth("R10 no stale second half", IDLE, IDLE);

    // R5: wrap from the highest warp back to the lowest.
    cycle("R5 first",  W47|W46|48'h3, 48'h0, 48'h0, ex(1,0,0),  ex(0,0,0));
    cycle("R5 first h1", W47|W46|48'h3, 48'h0, 48'h0, ex(1,0,1),  ex(0,0,1));
    cycle("R5 top",    W47|W46|48'h3, 48'h0, 48'h0, ex(47,0,0), ex(46,0,0));
    cycle("R5 top h1", W47|W46|48'h3, 48'h0, 48'h0, ex(47,0,1), ex(46,0,1));
    cycle("R5 wrapped", W47|W46|48'h3, 48'h0, 48'h0, ex(1,0,0), ex(0,0,0));
    cycle("R5 wrapped h1", W47|W46|48'h3, 48'h0, 48'h0, ex(1,0,1), ex(0,0,1));

    // R9: class code 3 passes through and does not block the peer.
    resetCycle("R9 reset");
    drive(48'h3, 48'h0, 48'h0, 48'h2);
    checkBoth("R9 code 3 non double", ex(1,3,0), ex(0,0,0));
    cycle("R9 code 3 second half", 48'h3, 48'h0, 48'h2, ex(1,3,1), ex(0,0,1));

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired got running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule